// File: doc/BRIEF.md
# Infrared Mark/Symbol Capture Receiver

This block captures the timing of a demodulated remote-control input (infrared or UHF receiver output). The pin passes through a two-stage synchronizer and an optional inverter. It is then sampled on a tick produced by a programmable clock divider. Normally the divider is set so that one tick is 100 ns, which is a 10 MHz sample rate. For every symbol the block measures two counts in ticks:

- the mark count: how long the input stays active;
- the period count: the time from the start of that mark to the start of the next mark.

The space time is the period count minus the mark count. Each pair of counts is stored in an 8-entry FIFO. When a train ends and no further mark arrives within a programmable maximum period, the final entry carries the saturated period value 0xFFFF.

A capture state machine does the counting. It has four states:

- OFF: capture is disabled.
- WAIT: enabled, waiting for the first mark.
- MARK: the input is active.
- GAP: the input is inactive and the next mark is awaited.

Its transitions are:

- enable-on: OFF to WAIT.
- disable: any state to OFF.
- mark-start: WAIT to MARK.
- mark-end: MARK to GAP.
- next-mark: GAP to MARK. This transition pushes a normal entry.
- train-end: GAP to WAIT. This transition pushes a 0xFFFF entry.

Software reaches the block through a word-addressed register port. Read data is combinational. A read of the mark register pops the FIFO entry.

Top module: `irsym_rx`

## Requirements
- R1: After reset the FIFO status word (address 6) reads 0, the interrupt status (address 4) reads 0, and `irq` is low.
- R2: With receive enable set (control address 2, bit 0) and divisor D (address 0; a value of 0 acts as 1), a mark held for M ticks followed by a gap of S ticks and then a new mark gives a FIFO entry with mark count M and period count M+S. Here one tick is D clocks. The period is read at address 7 and the mark at address 8.
- R3: In the GAP state, when the incremented period count reaches the maximum period (address 1), the block pushes an entry {mark = M, period = 0xFFFF} and returns to WAIT. The accepted push sets interrupt status bit 1 (last symbol).
- R4: When control bit 1 (invert) is set, a low input is treated as mark.
- R5: Entries are read out in arrival order. Reading address 7 does not pop. Reading address 8 when the FIFO is not empty pops one entry. The FIFO status word carries the fill level in bits 15:8.
- R6: A push into a full FIFO (8 entries) is dropped and the stored entries are kept. A dropped push sets the sticky overflow flag (FIFO status bit 2) and interrupt status bit 2 (overrun). A push that fills the FIFO sets interrupt status bit 3 (full). Writing 1 to bit 2 of address 5 also clears the overflow flag.
- R7: Every accepted push sets interrupt status bit 0 (data available). Writing address 5 clears exactly the status bits written as 1. A set event in the same cycle wins over the clear.
- R8: `irq` equals the OR over the four bits of (interrupt status AND interrupt enable). The interrupt enable is at address 3.
- R9: While receive enable is 0, no entries are pushed and no interrupt status bits are set, whatever the input does.
- R10: The mark and period counters saturate at 0xFFFF. A mark longer than 65535 ticks is reported as mark 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated receiver output (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at address 8) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sends random trains of marks and gaps at several divisor values and compares every FIFO entry with M and M+S. An off-by-one in either counter, or a sampling phase that drifts between edges, would show up as a mismatch.

It overfills the FIFO with ten pushes and checks three things:
- the first eight entries survive;
- the full and overrun bits are set;
- the last-symbol bit is not set, because the train-end push was dropped.

A design that overwrote the oldest entries, or that flagged events from dropped pushes, would fail these checks.

It also covers the following cases, each with the failure it would catch:

| Case | A design that got it wrong would |
|---|---|
| Train end | push a normal entry instead of the 0xFFFF entry |
| Inverted input | capture gaps as marks |
| Disabled capture | still count and push |
| Mark longer than 65535 ticks | wrap the counter to a small value instead of saturating |
| Partial interrupt clear | clear bits that were not written as 1 |

// File: rtl/irsym_pkg.sv
package irsym_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_WAIT = 2'd1,
        CAP_MARK = 2'd2,
        CAP_GAP  = 2'd3
    } cap_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] mark;
        logic [CNT_W-1:0] period;
    } sym_entry_t;

    localparam int ENTRY_W = 2 * CNT_W;

    // register word addresses
    localparam logic [3:0] A_DIV    = 4'h0;
    localparam logic [3:0] A_MAXPER = 4'h1;
    localparam logic [3:0] A_CTRL   = 4'h2;
    localparam logic [3:0] A_IEN    = 4'h3;
    localparam logic [3:0] A_ISTAT  = 4'h4;
    localparam logic [3:0] A_ICLR   = 4'h5;
    localparam logic [3:0] A_FSTAT  = 4'h6;
    localparam logic [3:0] A_PERIOD = 4'h7;
    localparam logic [3:0] A_MARK   = 4'h8;

    // interrupt bit positions
    localparam int IB_DATA  = 0;
    localparam int IB_LAST  = 1;
    localparam int IB_OVRUN = 2;
    localparam int IB_FULL  = 3;
    localparam int NUM_IRQ  = 4;

endpackage

// File: rtl/irsym_prescale.sv
module irsym_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last_cnt;

    always_comb begin
        last_cnt = (div == '0) ? '0 : div - 1'b1;
        tick     = (cnt_q >= last_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/irsym_sync.sv
module irsym_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic invert,
    output logic level
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    assign level = chain_q[STAGES-1] ^ invert;
endmodule

// File: rtl/irsym_capture.sv
module irsym_capture
    import irsym_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         level,
    input  logic         enable,
    input  logic [W-1:0] max_per,
    output logic         push,
    output logic         push_last,
    output logic [W-1:0] push_mark,
    output logic [W-1:0] push_period
);
    localparam logic [W-1:0] SAT = '1;
    localparam logic [W-1:0] ONE = W'(1);

    cap_state_e state_q, state_d;
    logic [W-1:0] mark_q, sym_q;
    logic [W-1:0] mark_inc, sym_inc;
    logic         timeout;

    always_comb begin
        mark_inc = (mark_q == SAT) ? SAT : mark_q + 1'b1;
        sym_inc  = (sym_q == SAT) ? SAT : sym_q + 1'b1;
        timeout  = (sym_inc >= max_per);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = CAP_OFF;
        end else begin
            unique case (state_q)
                CAP_OFF:  state_d = CAP_WAIT;
                CAP_WAIT: if (tick && level) state_d = CAP_MARK;
                CAP_MARK: if (tick && !level) state_d = CAP_GAP;
                CAP_GAP: begin
                    if (tick && level)        state_d = CAP_MARK;
                    else if (tick && timeout) state_d = CAP_WAIT;
                end
                default:  state_d = CAP_OFF;
            endcase
        end
    end

    // counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mark_q <= '0;
            sym_q  <= '0;
        end else if (!enable) begin
            mark_q <= '0;
            sym_q  <= '0;
        end else if (tick) begin
            unique case (state_q)
                CAP_WAIT: begin
                    if (level) begin
                        mark_q <= ONE;
                        sym_q  <= ONE;
                    end
                end
                CAP_MARK: begin
                    if (level) mark_q <= mark_inc;
                    sym_q <= sym_inc;
                end
                CAP_GAP: begin
                    if (level) begin
                        mark_q <= ONE;
                        sym_q  <= ONE;
                    end else begin
                        sym_q <= sym_inc;
                    end
                end
                default: begin
                    mark_q <= '0;
                    sym_q  <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        push        = enable && tick && (state_q == CAP_GAP) && (level || timeout);
        push_last   = !level;
        push_mark   = mark_q;
        push_period = level ? sym_q : SAT;
    end
endmodule

// File: rtl/irsym_fifo.sv
module irsym_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             do_push, do_pop;

    always_comb begin
        full    = (count_q == FULL_LVL);
        empty   = (count_q == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        drop    = push && full;
        count   = count_q;
        dout    = mem[rd_ptr_q];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end
endmodule

// File: rtl/irsym_rx.sv
module irsym_rx
    import irsym_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(1),
    parameter logic [CNT_W-1:0] MAXPER_RESET = '1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_in,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq
);
    localparam int FCNT_W = $clog2(DEPTH + 1);
    localparam logic [FCNT_W-1:0] NEAR_FULL = FCNT_W'(DEPTH - 1);

    // register state
    logic [DIV_W-1:0]   div_q;
    logic [CNT_W-1:0]   maxper_q;
    logic               rx_en_q, inv_q;
    logic [NUM_IRQ-1:0] ien_q, istat_q;
    logic               ovf_q;

    // internal nets
    logic               tick, level;
    logic               cap_push, cap_last;
    logic [CNT_W-1:0]   cap_mark, cap_period;
    sym_entry_t         push_entry, head;
    logic [ENTRY_W-1:0] head_raw;
    logic [FCNT_W-1:0]  fifo_cnt;
    logic               fifo_full, fifo_empty, fifo_drop, fifo_pop;
    logic [NUM_IRQ-1:0] set_mask, clr_mask;
    logic               accepted;

    irsym_prescale #(.DIV_W(DIV_W)) u_prescale (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (div_q),
        .tick (tick)
    );

    irsym_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ir_in),
        .invert(inv_q),
        .level (level)
    );

    irsym_capture #(.W(CNT_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .level      (level),
        .enable     (rx_en_q),
        .max_per    (maxper_q),
        .push       (cap_push),
        .push_last  (cap_last),
        .push_mark  (cap_mark),
        .push_period(cap_period)
    );

    assign push_entry = '{mark: cap_mark, period: cap_period};

    irsym_fifo #(.DEPTH(DEPTH), .W(ENTRY_W), .CNT_W(FCNT_W)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (cap_push),
        .din  (push_entry),
        .pop  (fifo_pop),
        .dout (head_raw),
        .count(fifo_cnt),
        .full (fifo_full),
        .empty(fifo_empty),
        .drop (fifo_drop)
    );

    assign head = sym_entry_t'(head_raw);

    always_comb begin
        fifo_pop = reg_rd && (reg_addr == A_MARK) && !fifo_empty;
        accepted = cap_push && !fifo_full;
        set_mask = '0;
        set_mask[IB_DATA]  = accepted;
        set_mask[IB_LAST]  = accepted && cap_last;
        set_mask[IB_OVRUN] = fifo_drop;
        set_mask[IB_FULL]  = accepted && !fifo_pop && (fifo_cnt == NEAR_FULL);
        clr_mask = (reg_wr && reg_addr == A_ICLR) ? reg_wdata[NUM_IRQ-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q    <= DIV_RESET;
            maxper_q <= MAXPER_RESET;
            rx_en_q  <= 1'b0;
            inv_q    <= 1'b0;
            ien_q    <= '0;
            istat_q  <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    A_DIV:    div_q    <= reg_wdata[DIV_W-1:0];
                    A_MAXPER: maxper_q <= reg_wdata[CNT_W-1:0];
                    A_CTRL: begin
                        rx_en_q <= reg_wdata[0];
                        inv_q   <= reg_wdata[1];
                    end
                    A_IEN:    ien_q    <= reg_wdata[NUM_IRQ-1:0];
                    default:  ;
                endcase
            end
            istat_q <= (istat_q & ~clr_mask) | set_mask;
            if (fifo_drop)               ovf_q <= 1'b1;
            else if (clr_mask[IB_OVRUN]) ovf_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_DIV:    reg_rdata = 16'(div_q);
            A_MAXPER: reg_rdata = 16'(maxper_q);
            A_CTRL:   reg_rdata = {14'd0, inv_q, rx_en_q};
            A_IEN:    reg_rdata = 16'(ien_q);
            A_ISTAT:  reg_rdata = 16'(istat_q);
            A_FSTAT: begin
                reg_rdata[15:8] = 8'(fifo_cnt);
                reg_rdata[2]    = ovf_q;
            end
            A_PERIOD: reg_rdata = 16'(head.period);
            A_MARK:   reg_rdata = 16'(head.mark);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(istat_q & ien_q);
endmodule

// File: rtl/irsym_rx_chk.sv
module irsym_rx_chk #(
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 16,
    parameter int FCNT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_push,
    input logic [CNT_W-1:0]  cap_mark,
    input logic [CNT_W-1:0]  cap_period,
    input logic [FCNT_W-1:0] fifo_cnt,
    input logic              fifo_full,
    input logic              rx_en,
    input logic              ovf,
    input logic [3:0]        ien,
    input logic              irq
);
    localparam logic [CNT_W-1:0]  SAT      = '1;
    localparam logic [FCNT_W-1:0] FULL_LVL = FCNT_W'(DEPTH);

    // R2: a normal entry always has a gap, so mark is shorter than period
    a_r2_mark_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_push && cap_period != SAT) |-> (cap_mark < cap_period));

    // R9: nothing is pushed while capture is disabled
    a_r9_no_push_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> !cap_push);

    // R6: a push into a full FIFO leaves the overflow flag set
    a_r6_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_push && fifo_full) |=> ovf);

    // R5: fill level never exceeds the depth
    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= FULL_LVL);

    // R5: fill level moves by at most one per cycle
    a_r5_level_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fifo_cnt == $past(fifo_cnt) ||
                  fifo_cnt == $past(fifo_cnt) + 1'b1 ||
                  fifo_cnt == $past(fifo_cnt) - 1'b1));

    // R8: no interrupt while every source is masked
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 4'd0) |-> !irq);
endmodule

bind irsym_rx irsym_rx_chk #(.DEPTH(DEPTH), .CNT_W(irsym_pkg::CNT_W), .FCNT_W(FCNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_push  (cap_push),
    .cap_mark  (cap_mark),
    .cap_period(cap_period),
    .fifo_cnt  (fifo_cnt),
    .fifo_full (fifo_full),
    .rx_en     (rx_en_q),
    .ovf       (ovf_q),
    .ien       (ien_q),
    .irq       (irq)
);

// File: tb/irsym_rx_tb_top.sv
module irsym_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int div_b = 1;
    logic act_lvl = 1'b1;
    logic [31:0] expq[$];

    irsym_rx dut_i (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] fstat_word(input int fill, input bit ovf);
        logic [15:0] w;
        w = 16'h0;
        w[15:8] = 8'(fill);
        w[2] = ovf;
        return w;
    endfunction

    function automatic logic [31:0] entry(input int m, input int p);
        return {16'(m), 16'(p)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pop_entry(output logic [31:0] e);
        logic [15:0] p;
        rd_reg(4'h7, p);
        @(negedge clk);
        reg_addr = 4'h8; reg_rd = 1'b1;
        #1 e = {reg_rdata, p};
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one symbol: M ticks active, S ticks inactive
    task automatic send_sym(input int m, input int s);
        ir_in = act_lvl;
        idle(m * div_b);
        ir_in = ~act_lvl;
        idle(s * div_b);
    endtask

    // last mark followed by a gap long enough to end the train
    task automatic send_last(input int m, input int maxper);
        ir_in = act_lvl;
        idle(m * div_b);
        ir_in = ~act_lvl;
        idle((maxper + 4) * div_b + 8);
    endtask

    task automatic drain_check(input string req);
        logic [31:0] e;
        while (expq.size() > 0) begin
            pop_entry(e);
            chk(req, e, expq.pop_front());
        end
    endtask

    initial begin
        int seed;
        logic [15:0] d;
        logic [31:0] e;
        seed = $urandom(32'd1234);
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd_reg(4'h6, d); chk("R1 fifo status", 32'(d), 32'(fstat_word(0, 0)));
        rd_reg(4'h4, d); chk("R1 irq status", 32'(d), 32'h0);
        chk("R1 irq pin", 32'(irq), 32'h0);

        // R2/R3/R5 random trains
        wr_reg(4'h1, 16'd200);
        for (int it = 0; it < 3; it++) begin
            int n;
            div_b = 1 + int'($urandom % 4);
            wr_reg(4'h0, 16'(div_b));
            wr_reg(4'h2, 16'h1);
            idle(8);
            n = 2 + int'($urandom % 6);
            for (int k = 0; k < n - 1; k++) begin
                int m, s;
                m = 1 + int'($urandom % 20);
                s = 1 + int'($urandom % 30);
                expq.push_back(entry(m, m + s));
                send_sym(m, s);
            end
            begin
                int m;
                m = 1 + int'($urandom % 20);
                expq.push_back(entry(m, 16'hFFFF));
                send_last(m, 200);
            end
            rd_reg(4'h6, d); chk("R5 fill level", 32'(d), 32'(fstat_word(n, 0)));
            rd_reg(4'h4, d); chk("R3 last-symbol status", 32'(d[1]), 32'h1);
            rd_reg(4'h7, d); rd_reg(4'h7, d);
            rd_reg(4'h6, d); chk("R5 period read does not pop", 32'(d), 32'(fstat_word(n, 0)));
            drain_check("R2/R3 entry");
            rd_reg(4'h6, d); chk("R5 drained", 32'(d), 32'(fstat_word(0, 0)));

            // R7 partial clear
            wr_reg(4'h5, 16'h1);
            rd_reg(4'h4, d); chk("R7 clear only bit 0", 32'(d), 32'h2);
            wr_reg(4'h5, 16'h2);
            rd_reg(4'h4, d); chk("R7 clear bit 1", 32'(d), 32'h0);
        end

        // R4 inverted input
        wr_reg(4'h2, 16'h0);
        div_b = 2;
        wr_reg(4'h0, 16'd2);
        ir_in = 1'b1;
        idle(6);
        act_lvl = 1'b0;
        wr_reg(4'h2, 16'h3);
        idle(8);
        expq.push_back(entry(5, 12));
        send_sym(5, 7);
        expq.push_back(entry(9, 16'hFFFF));
        send_last(9, 200);
        drain_check("R4 inverted entry");
        wr_reg(4'h2, 16'h0);
        ir_in = 1'b0;
        act_lvl = 1'b1;
        idle(6);
        wr_reg(4'h5, 16'hF);

        // R8 interrupt combine
        div_b = 1;
        wr_reg(4'h0, 16'd1);
        wr_reg(4'h2, 16'h1);
        wr_reg(4'h3, 16'h2);
        idle(6);
        send_last(2, 200);
        #1 chk("R8 irq with last enabled", 32'(irq), 32'h1);
        wr_reg(4'h3, 16'h0);
        #1 chk("R8 irq masked", 32'(irq), 32'h0);
        wr_reg(4'h3, 16'h8);
        #1 chk("R8 irq full bit not set", 32'(irq), 32'h0);
        wr_reg(4'h3, 16'h1);
        #1 chk("R8 irq data enabled", 32'(irq), 32'h1);
        pop_entry(e); chk("R3 single-mark entry", e, entry(2, 16'hFFFF));
        wr_reg(4'h5, 16'hF);
        #1 chk("R8 irq after clear", 32'(irq), 32'h0);
        wr_reg(4'h3, 16'h0);

        // R6 overflow: ten pushes into eight entries
        for (int k = 0; k < 9; k++) begin
            if (k < 8) expq.push_back(entry(3, 7));
            send_sym(3, 4);
        end
        send_last(3, 200);
        rd_reg(4'h6, d); chk("R6 full and overflow", 32'(d), 32'(fstat_word(8, 1)));
        rd_reg(4'h4, d); chk("R6 status full+overrun+data", 32'(d), 32'hD);
        drain_check("R6 kept entry");
        wr_reg(4'h5, 16'hF);
        rd_reg(4'h6, d); chk("R6 overflow cleared", 32'(d), 32'(fstat_word(0, 0)));

        // R9 disabled capture
        wr_reg(4'h2, 16'h0);
        for (int k = 0; k < 6; k++) send_sym(4, 5);
        idle(300);
        rd_reg(4'h6, d); chk("R9 no push when disabled", 32'(d), 32'(fstat_word(0, 0)));
        rd_reg(4'h4, d); chk("R9 no status when disabled", 32'(d), 32'h0);

        // R10 saturation
        wr_reg(4'h1, 16'hFFFF);
        wr_reg(4'h2, 16'h1);
        idle(6);
        ir_in = 1'b1;
        idle(70000);
        ir_in = 1'b0;
        idle(20);
        rd_reg(4'h6, d); chk("R10 one entry", 32'(d), 32'(fstat_word(1, 0)));
        pop_entry(e); chk("R10 saturated entry", e, entry(16'hFFFF, 16'hFFFF));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule